// File: doc/BRIEF.md
# Buzzer Tone Generator

This block drives a piezo buzzer with a square wave. It has a true output and a complement output. All timing comes from a base tick: a one-cycle enable pulse at the 32.768 kHz low-speed rate, sampled in the system clock domain.

Software writes one register word through a simple write strobe. The word holds three fields:
- an on bit;
- a 2-bit sound mode;
- a 4-bit step code that picks one of 15 tone pitches, from about 5.46 kHz down to about 0.96 kHz.

The sound modes are:
- a steady tone;
- a one-shot beep that switches itself off;
- two repeating on/off patterns.

While the tone is silenced, both outputs rest low, so no DC stands across the buzzer. A new pitch written during sound is held back until the current tone period finishes. This prevents a short runt pulse.

A write always restarts the on/off pattern from its beginning. `run_flag` shows the on bit, so software can see when a one-shot beep has ended.

Top module: `buzzer_gen`

## Requirements
- R1: After reset, `buzz_p`, `buzz_n` and `run_flag` are 0. Whenever `run_flag` is 0, both buzz outputs are 0.
- R2: Step code s (1..15) gives a tone whose high half and low half each last s+2 base ticks, so the full period is 2s+4 ticks (6 ticks for code 1, 34 ticks for code 15). When sound starts, `buzz_p` is high in the first cycle after the write.
- R3: While sounding, `buzz_n` is the complement of `buzz_p`. The two outputs are never high together.
- R4: Step code 0 means silence. When code 0 is written with the on bit set from the idle state, `run_flag` goes to 1 but both outputs stay low.
- R5: Mode code 0 (steady) sounds for as long as the on bit is set.
- R6: Mode code 2 (pattern A) repeats: sound for UNIT_TICKS base ticks, then silence for UNIT_TICKS ticks. The default UNIT_TICKS of 2048 gives 62.5 ms.
- R7: Mode code 3 (pattern B) repeats: sound for 2×UNIT_TICKS ticks, then silence for 6×UNIT_TICKS ticks. At the default this is 125 ms on and 375 ms off.
- R8: Mode code 1 (one-shot) sounds for 2×UNIT_TICKS ticks. It then clears `run_flag` by itself. `run_flag` falls without a write only in this mode.
- R9: A new step code written during sound first takes effect when the current low half ends. The next high half already uses the new length.
- R10: A write with the on bit clear silences both outputs and clears `run_flag` in the first cycle after the write. Any write restarts the on/off pattern at its beginning.
- R11: While `base_tick` is low and there is no write, the outputs and `run_flag` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | One-cycle pulse at the base (32.768 kHz) rate |
| wr_en | input | 1 | Register write strobe |
| wr_on | input | 1 | On bit written with the strobe |
| wr_mode | input | 2 | Sound mode: 0 steady, 1 one-shot, 2 pattern A, 3 pattern B |
| wr_step | input | STEP_W | Pitch step code; 0 means silence |
| buzz_p | output | 1 | Buzzer drive, true phase |
| buzz_n | output | 1 | Buzzer drive, complement phase |
| run_flag | output | 1 | Current state of the on bit |

## Verification
The hardest situations to reach come from collisions between pending state and writes:
- a pitch write that lands partway through a tone half and must wait for the next period boundary;
- a write that meets the one-shot beep in the very cycle it clears itself.

Both depend on the tick phase at the moment of the write. The stimulus therefore ends with a long stretch of writes at random times, with random fields and irregular tick spacing. A behavioural model is compared against the outputs on every cycle throughout that stretch. Directed passes first pin down the period lengths, the pattern duty counts, the freeze with no ticks and the immediate stop.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
   typedef enum logic [1:0] {
      MODE_STEADY  = 2'd0,
      MODE_ONESHOT = 2'd1,
      MODE_PULSE_A = 2'd2,
      MODE_PULSE_B = 2'd3
   } buzz_mode_e;
endpackage

// File: rtl/buzz_tone_div.sv
// Half-period counter for the tone; the pitch is reloaded at period boundaries.
module buzz_tone_div #(
   parameter int STEP_W   = 4,
   parameter int DIV_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate_on,
   input  logic [STEP_W-1:0] step_next,
   output logic              tone,
   output logic              sounding
);
   localparam int HP_W = $clog2((1 << STEP_W) + DIV_BASE / 2) + 1;

   logic [STEP_W-1:0] step_act;
   logic [HP_W-1:0]   ph_cnt;
   logic [HP_W-1:0]   hp_len;

   assign hp_len   = HP_W'(step_act) + HP_W'(DIV_BASE / 2);
   assign sounding = gate_on && (step_act != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt   <= '0;
         tone     <= 1'b1;
         step_act <= '0;
      end else if (!sounding) begin
         // silent: restart the phase and take the latest pitch at once
         ph_cnt   <= '0;
         tone     <= 1'b1;
         step_act <= step_next;
      end else if (tick) begin
         if (ph_cnt == hp_len - 1'b1) begin
            ph_cnt <= '0;
            tone   <= ~tone;
            if (!tone) begin
               step_act <= step_next;   // the low half ended: period boundary
            end
         end else begin
            ph_cnt <= ph_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/buzz_mode_seq.sv
// Holds the on bit and the position in the sound pattern, and produces the gate.
module buzz_mode_seq
   import buzz_pkg::*;
#(
   parameter int UNIT_TICKS  = 2048,
   parameter int A_ON_UNITS  = 1,
   parameter int A_OFF_UNITS = 1,
   parameter int B_ON_UNITS  = 2,
   parameter int B_OFF_UNITS = 6,
   parameter int BEEP_UNITS  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr_en,
   input  logic       wr_on,
   input  buzz_mode_e mode,
   output logic       run,
   output logic       gate
);
   localparam int A_LEN    = (A_ON_UNITS + A_OFF_UNITS) * UNIT_TICKS;
   localparam int B_LEN    = (B_ON_UNITS + B_OFF_UNITS) * UNIT_TICKS;
   localparam int BEEP_LEN = BEEP_UNITS * UNIT_TICKS;
   localparam int MAX_AB   = (A_LEN > B_LEN) ? A_LEN : B_LEN;
   localparam int MAX_LEN  = (MAX_AB > BEEP_LEN) ? MAX_AB : BEEP_LEN;
   localparam int SEQ_W    = $clog2(MAX_LEN + 1);

   localparam logic [SEQ_W-1:0] A_LAST    = SEQ_W'(A_LEN - 1);
   localparam logic [SEQ_W-1:0] B_LAST    = SEQ_W'(B_LEN - 1);
   localparam logic [SEQ_W-1:0] BEEP_LAST = SEQ_W'(BEEP_LEN - 1);
   localparam logic [SEQ_W-1:0] A_ON_END  = SEQ_W'(A_ON_UNITS * UNIT_TICKS);
   localparam logic [SEQ_W-1:0] B_ON_END  = SEQ_W'(B_ON_UNITS * UNIT_TICKS);

   logic [SEQ_W-1:0] seq_cnt;

   always_comb begin
      case (mode)
         MODE_PULSE_A: gate = (seq_cnt < A_ON_END);
         MODE_PULSE_B: gate = (seq_cnt < B_ON_END);
         default:      gate = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         seq_cnt <= '0;
      end else if (wr_en) begin
         run     <= wr_on;
         seq_cnt <= '0;
      end else if (run && tick) begin
         case (mode)
            MODE_ONESHOT: begin
               if (seq_cnt == BEEP_LAST) begin
                  run     <= 1'b0;
                  seq_cnt <= '0;
               end else begin
                  seq_cnt <= seq_cnt + 1'b1;
               end
            end
            MODE_PULSE_A: seq_cnt <= (seq_cnt == A_LAST) ? '0 : seq_cnt + 1'b1;
            MODE_PULSE_B: seq_cnt <= (seq_cnt == B_LAST) ? '0 : seq_cnt + 1'b1;
            default:      seq_cnt <= '0;
         endcase
      end else if (!run) begin
         seq_cnt <= '0;
      end
   end
endmodule

// File: rtl/buzz_pair_drv.sv
// Complementary output pair; both outputs rest low while silent.
module buzz_pair_drv (
   input  logic sounding,
   input  logic tone,
   output logic drv_p,
   output logic drv_n
);
   assign drv_p = sounding &  tone;
   assign drv_n = sounding & ~tone;
endmodule

// File: rtl/buzzer_gen.sv
module buzzer_gen
   import buzz_pkg::*;
#(
   parameter int STEP_W      = 4,
   parameter int DIV_BASE    = 4,
   parameter int UNIT_TICKS  = 2048,
   parameter int A_ON_UNITS  = 1,
   parameter int A_OFF_UNITS = 1,
   parameter int B_ON_UNITS  = 2,
   parameter int B_OFF_UNITS = 6,
   parameter int BEEP_UNITS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              wr_en,
   input  logic              wr_on,
   input  logic [1:0]        wr_mode,
   input  logic [STEP_W-1:0] wr_step,
   output logic              buzz_p,
   output logic              buzz_n,
   output logic              run_flag
);
   // elaboration-time parameter checks
   if (STEP_W < 2 || STEP_W > 8) begin : g_bad_step_w
      $error("buzzer_gen: STEP_W must be in 2..8");
   end
   if (DIV_BASE < 2 || (DIV_BASE % 2) != 0) begin : g_bad_div
      $error("buzzer_gen: DIV_BASE must be even and at least 2");
   end
   if (UNIT_TICKS < 1) begin : g_bad_unit
      $error("buzzer_gen: UNIT_TICKS must be positive");
   end
   if (A_ON_UNITS < 1 || A_OFF_UNITS < 1 || B_ON_UNITS < 1 || B_OFF_UNITS < 1
       || BEEP_UNITS < 1) begin : g_bad_pattern
      $error("buzzer_gen: pattern unit counts must be positive");
   end

   buzz_mode_e        mode_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] step_next;
   logic              seq_run;
   logic              seq_gate;
   logic              tone;
   logic              sounding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_STEADY;
         step_q <= '0;
      end else if (wr_en) begin
         mode_q <= buzz_mode_e'(wr_mode);
         step_q <= wr_step;
      end
   end

   assign step_next = wr_en ? wr_step : step_q;

   buzz_mode_seq #(
      .UNIT_TICKS (UNIT_TICKS),
      .A_ON_UNITS (A_ON_UNITS),
      .A_OFF_UNITS(A_OFF_UNITS),
      .B_ON_UNITS (B_ON_UNITS),
      .B_OFF_UNITS(B_OFF_UNITS),
      .BEEP_UNITS (BEEP_UNITS)
   ) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (base_tick),
      .wr_en(wr_en),
      .wr_on(wr_on),
      .mode (mode_q),
      .run  (seq_run),
      .gate (seq_gate)
   );

   buzz_tone_div #(
      .STEP_W  (STEP_W),
      .DIV_BASE(DIV_BASE)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (base_tick),
      .gate_on  (seq_run && seq_gate),
      .step_next(step_next),
      .tone     (tone),
      .sounding (sounding)
   );

   buzz_pair_drv u_drv (
      .sounding(sounding),
      .tone    (tone),
      .drv_p   (buzz_p),
      .drv_n   (buzz_n)
   );

   assign run_flag = seq_run;
endmodule

// File: rtl/buzzer_gen_chk.sv
module buzzer_gen_chk #(
   parameter int STEP_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              base_tick,
   input logic              wr_en,
   input logic              wr_on,
   input logic [STEP_W-1:0] wr_step,
   input logic [1:0]        mode_q,
   input logic              buzz_p,
   input logic              buzz_n,
   input logic              run_flag
);
   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_flag |-> (!buzz_p && !buzz_n));

   assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_on && !run_flag && wr_step != '0) |=> buzz_p);

   assert_never_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(buzz_p && buzz_n));

   assert_zero_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_on && !run_flag && wr_step == '0) |=> (run_flag && !buzz_p && !buzz_n));

   // R8: without a write, only the one-shot mode ends the sound by itself
   assert_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_flag) && !$past(wr_en)) |-> ($past(mode_q) == 2'd1));

   assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_on) |=> (!run_flag && !buzz_p && !buzz_n));

   assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!base_tick && !wr_en) |=> ($stable(buzz_p) && $stable(buzz_n) && $stable(run_flag)));
endmodule

bind buzzer_gen buzzer_gen_chk #(.STEP_W(STEP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .base_tick(base_tick),
   .wr_en    (wr_en),
   .wr_on    (wr_on),
   .wr_step  (wr_step),
   .mode_q   (mode_q),
   .buzz_p   (buzz_p),
   .buzz_n   (buzz_n),
   .run_flag (run_flag)
);

// File: tb/sim_buzzer_gen.sv
`timescale 1ns/1ps
module sim_buzzer_gen;
   localparam int U = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_on = 1'b0;
   logic [1:0] wr_mode = 2'd0;
   logic [3:0] wr_step = 4'd0;
   logic       buzz_p, buzz_n, run_flag;

   int    vectors = 0;
   int    miscompares = 0;
   int    tick_mode = 0;
   string phase_req = "R1";
   bit    done = 1'b0;

   always #2 clk = ~clk;

   buzzer_gen #(.UNIT_TICKS(U)) u0 (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en), .wr_on(wr_on),
      .wr_mode(wr_mode), .wr_step(wr_step), .buzz_p(buzz_p), .buzz_n(buzz_n),
      .run_flag(run_flag));

   // ---------------- behavioural reference model ----------------
   int m_run, m_mode, m_step, m_act, m_ph, m_tone, m_cnt;

   function automatic int model_gate(int mode, int cnt);
      if (mode == 2) return ((cnt % (2 * U)) < U) ? 1 : 0;
      if (mode == 3) return ((cnt % (8 * U)) < 2 * U) ? 1 : 0;
      return 1;
   endfunction

   function automatic int model_snd();
      return (m_run != 0 && model_gate(m_mode, m_cnt) != 0 && m_act != 0) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_mode = 0; m_step = 0; m_act = 0; m_ph = 0; m_tone = 1; m_cnt = 0;
      end else begin
         int snd, nxt;
         snd = model_snd();
         nxt = wr_en ? int'(wr_step) : m_step;
         if (snd == 0) begin
            m_ph = 0; m_tone = 1; m_act = nxt;
         end else if (base_tick) begin
            m_ph = m_ph + 1;
            if (m_ph >= m_act + 2) begin
               m_ph = 0;
               if (m_tone == 0) m_act = nxt;
               m_tone = 1 - m_tone;
            end
         end
         if (wr_en) begin
            m_run = int'(wr_on); m_cnt = 0;
         end else if (m_run != 0 && base_tick) begin
            if (m_mode == 1) begin
               m_cnt = m_cnt + 1;
               if (m_cnt == 2 * U) begin m_run = 0; m_cnt = 0; end
            end else if (m_mode == 2) m_cnt = (m_cnt + 1) % (2 * U);
            else if (m_mode == 3) m_cnt = (m_cnt + 1) % (8 * U);
            else m_cnt = 0;
         end else if (m_run == 0) m_cnt = 0;
         if (wr_en) begin m_mode = int'(wr_mode); m_step = int'(wr_step); end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison (R3 complement and idle-low are part of every vector)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int s, ep, en;
         s  = model_snd();
         ep = s & m_tone;
         en = s & (1 - m_tone);
         vectors++;
         if (buzz_p !== ep[0] || buzz_n !== en[0] || run_flag !== (m_run != 0)) begin
            miscompares++;
            $display("FAIL %s per-cycle R3: actual p%0b n%0b run%0b expected p%0d n%0d run%0d at %0t",
                     phase_req, buzz_p, buzz_n, run_flag, ep, en, m_run, $time);
         end
      end
   end

   // base tick source
   initial begin
      forever begin
         @(negedge clk);
         case (tick_mode)
            0:       base_tick = 1'b1;
            1:       base_tick = ~base_tick;
            2:       base_tick = (($urandom % 3) != 0);
            default: base_tick = 1'b0;
         endcase
      end
   end

   task automatic do_write(input bit on, input int mode, input int step);
      @(negedge clk);
      wr_en = 1'b1; wr_on = on; wr_mode = 2'(mode); wr_step = 4'(step);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // samples n cycles starting now; counts rises of buzz_p and sounding cycles
   task automatic observe(input int n, output int rises, output int snd_cycles);
      logic prev = 1'b0;
      rises = 0; snd_cycles = 0;
      for (int i = 0; i < n; i++) begin
         if (buzz_p && !prev) rises++;
         if (buzz_p || buzz_n) snd_cycles++;
         prev = buzz_p;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int r, sc;
      logic sp, sn, sr;
      repeat (3) @(negedge clk);
      check("R1", "buzz_p in reset", int'(buzz_p), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "buzz_p after reset", int'(buzz_p), 0);
      check("R1", "buzz_n after reset", int'(buzz_n), 0);
      check("R1", "run_flag after reset", int'(run_flag), 0);

      // R2/R5: steady tone, highest pitch (period 6)
      phase_req = "R2"; tick_mode = 0;
      do_write(1'b1, 0, 1);
      check("R2", "first cycle high", int'(buzz_p), 1);
      observe(60, r, sc);
      check("R2", "rises step1 in 60 ticks", r, 10);
      check("R5", "steady sound cycles", sc, 60);

      // R2: lowest pitch (period 34)
      do_write(1'b0, 0, 0);
      do_write(1'b1, 0, 15);
      observe(340, r, sc);
      check("R2", "rises step15 in 340 ticks", r, 10);

      // R9: pitch change during sound
      phase_req = "R9";
      do_write(1'b1, 0, 1);
      repeat (10) @(negedge clk);
      do_write(1'b1, 0, 15);
      repeat (40) @(negedge clk);
      observe(340, r, sc);
      check("R9", "rises after change to step15", r, 10);

      // R11: freeze with no ticks
      phase_req = "R11"; tick_mode = 3;
      @(negedge clk); @(negedge clk);
      sp = buzz_p; sn = buzz_n; sr = run_flag;
      repeat (50) begin
         @(negedge clk);
         check("R11", "buzz_p frozen", int'(buzz_p), int'(sp));
         check("R11", "buzz_n frozen", int'(buzz_n), int'(sn));
         check("R11", "run frozen", int'(run_flag), int'(sr));
      end
      tick_mode = 0;

      // R10: immediate stop
      phase_req = "R10";
      do_write(1'b0, 0, 15);
      check("R10", "buzz_p after off", int'(buzz_p), 0);
      check("R10", "buzz_n after off", int'(buzz_n), 0);
      check("R10", "run after off", int'(run_flag), 0);

      // R4: step 0 enabled is silent
      phase_req = "R4";
      do_write(1'b1, 0, 0);
      observe(40, r, sc);
      check("R4", "step0 sound cycles", sc, 0);
      check("R4", "step0 run_flag", int'(run_flag), 1);
      do_write(1'b0, 0, 0);

      // R6: pattern A
      phase_req = "R6";
      do_write(1'b1, 2, 2);
      observe(4 * U, r, sc);
      check("R6", "pattern A sound cycles", sc, 2 * U);
      do_write(1'b0, 0, 0);

      // R7: pattern B
      phase_req = "R7";
      do_write(1'b1, 3, 4);
      observe(8 * U, r, sc);
      check("R7", "pattern B sound cycles", sc, 2 * U);
      do_write(1'b0, 0, 0);

      // R8: one-shot beep
      phase_req = "R8";
      do_write(1'b1, 1, 3);
      observe(2 * U + 10, r, sc);
      check("R8", "beep sound cycles", sc, 2 * U);
      check("R8", "beep self-clear", int'(run_flag), 0);

      // R10 restart + mixed: random writes, irregular ticks, model compared each cycle
      phase_req = "R9"; tick_mode = 2;
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 120) == 0)
            do_write(1'(($urandom % 4) != 0), int'($urandom % 4), int'($urandom % 16));
         else
            @(negedge clk);
      end
      tick_mode = 1;
      do_write(1'b1, 1, 5);
      repeat (4 * U + 10) @(negedge clk);
      check("R8", "beep self-clear with half-rate ticks", int'(run_flag), 0);

      finish_run();
   end
endmodule